// File: doc/BRIEF.md
# Serial Peripheral Interface Byte Memory Slave

This block is the device side of an SPI link to a 32K x 8 byte memory. A host lowers the active-low select, sends a one-byte command and, for array transfers, a two-byte address, then streams data bytes in or out. The address counter advances after every data byte and rolls over at the top of the 15-bit space, so a single selection can move any number of bytes. A status register holds a write-protect enable bit and a two-bit block-protect field. It also shows the write-enable latch, which must be set by its own command before any write.

All pins are sampled by the system clock, and the block finds the serial clock edges itself. Input data is taken on serial clock rising edges, and output data changes on falling edges. The output is modelled as a data bit and an enable. An active-low hold pin freezes a transfer mid-stream, and an active-low write-protect pin guards the status register only. The storage model keeps `STORE_AW` address bits; the protocol always uses the full 15-bit address.

Top module: `spimem_slave`

## Requirements
- R1: While select is high, serial clock and data input activity has no effect: no command is decoded and `so_oe` stays 0.
- R2: Only the first byte after a falling select edge is decoded as a command. Later bytes in the same selection are never treated as commands.
- R3: Input bits are captured on serial clock rising edges and output bits change only on falling edges. Bytes travel MSB first.
- R4: Commands: 0x06 sets write-enable, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes it. Any other value is ignored until select is released. The address is two bytes, high byte first, and its top bit is ignored.
- R5: While hold is low, the transfer is suspended. Serial clock and select changes are ignored and `so_oe` is 0. When hold returns high, the transfer continues from the bit where it stopped.
- R6: A change on the hold pin is taken only while the serial clock is low. A hold pulse that starts and ends while the clock is high has no effect.
- R7: Array and status writes take effect only while the write-enable latch is set. The latch clears when select rises after a 0x01 or 0x02 command. The latch reads back as status bit 1.
- R8: The status read returns {bit7 protect-enable, 000, bits 3:2 block-protect, bit1 write-enable, 0}, and its value is 0x00 after reset. A status write loads bits 7 and 3:2. It is refused while bit 7 is 1 and `wp_n` is 0. `wp_n` never affects array writes.
- R9: Block-protect blocks array writes at or above an address threshold: 00 blocks none, 01 blocks 0x6000 and above, 10 blocks 0x4000 and above, 11 blocks all. The address still advances past a refused byte.
- R10: The address counter advances by one after each data byte in both directions and wraps from 0x7FFF to 0x0000.
- R11: `so_oe` is 1 only during the data phase of an array or status read. A status read repeats the status value for as many bytes as are clocked.
- R12: Storage holds 2^STORE_AW bytes (default 10), indexed by the low address bits. Higher addresses alias onto it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer suspend |
| wp_n | input | 1 | Active-low status write guard |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = not driven) |

## Verification
A wrong bit or phase counter shows as a shifted or misaligned read byte within the same selection, because every read is compared byte by byte with a bench model. A wrong write-enable latch or protection decision changes stored data silently, so every write is followed by a read-back or a status read in the next selection. A hold or select that leaks through shows either as a driven output during the freeze or as a corrupted byte on the first read after release.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam int SPI_ADDR_W = 15;

  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h05;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  localparam logic [7:0] CMD_ARR_RD  = 8'h03;
  localparam logic [7:0] CMD_ARR_WR  = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_ADR_HI, PH_ADR_LO, PH_WR_DATA,
    PH_RD_DATA, PH_WR_STAT, PH_RD_STAT, PH_DISCARD
  } phase_t;

  // Block-protect decision from the two top address bits.
  function automatic logic range_locked(input logic [1:0] bp_f, input logic [1:0] top2);
    case (bp_f)
      2'b00:   range_locked = 1'b0;
      2'b01:   range_locked = (top2 == 2'b11);
      2'b10:   range_locked = top2[1];
      default: range_locked = 1'b1;
    endcase
  endfunction

  function automatic logic stat_guarded(input logic guard_en, input logic wp_pin_n);
    stat_guarded = guard_en && !wp_pin_n;
  endfunction

endpackage

// File: rtl/spimem_pins.sv
module spimem_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic held,
  output logic sel_start_ev,
  output logic sel_end_ev,
  output logic sck_rise_ev,
  output logic sck_fall_ev
);
  logic held_q, cs_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
    end else begin
      sck_q <= sck;
      if (!sck)    held_q <= !hold_n;
      if (!held_q) cs_q   <= cs_n;
    end
  end

  assign held         = held_q;
  assign sel_start_ev = !held_q && cs_q && !cs_n;
  assign sel_end_ev   = !held_q && !cs_q && cs_n;
  assign sck_rise_ev  = !held_q && !cs_q && sck && !sck_q;
  assign sck_fall_ev  = !held_q && !cs_q && !sck && sck_q;

  AST_HOLD_ONLY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) sck |=> $stable(held_q)); // R6

endmodule

// File: rtl/spimem_store.sv
module spimem_store #(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << STORE_AW;

  logic [7:0]          cells [DEPTH];
  logic [STORE_AW-1:0] idx;

  assign idx = STORE_AW'(addr % DEPTH);

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/spimem_seq.sv
module spimem_seq
  import spimem_pkg::*;
#(
  parameter int ADDR_W = SPI_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              si,
  input  logic              wp_n,
  input  logic              sel_start_ev,
  input  logic              sel_end_ev,
  input  logic              sck_rise_ev,
  input  logic              sck_fall_ev,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              so_d,
  output logic              rd_active
);
  localparam int HI_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    addr_next = a + 1'b1;
  endfunction

  phase_t            ph;
  logic [2:0]        bit_cnt, out_cnt;
  logic [6:0]        shin;
  logic [ADDR_W-1:0] addr;
  logic              wel, wr_cmd, rd_cmd, out_started;
  logic              guard_en;
  logic [1:0]        bp_f;

  logic [7:0] byte_in, stat_val, rd_byte;
  logic       byte_done_ev, array_wr_ev, status_wr_ev, addr_step_ev, out_ev;

  assign byte_in      = {shin, si};
  assign byte_done_ev = sck_rise_ev && (bit_cnt == 3'd7);
  assign stat_val     = {guard_en, 3'b000, bp_f, wel, 1'b0};
  assign rd_byte      = (ph == PH_RD_STAT) ? stat_val : mem_rdata;
  assign array_wr_ev  = byte_done_ev && (ph == PH_WR_DATA) && wel &&
                        !range_locked(bp_f, addr[ADDR_W-1 -: 2]);
  assign status_wr_ev = byte_done_ev && (ph == PH_WR_STAT) && wel &&
                        !stat_guarded(guard_en, wp_n);
  assign addr_step_ev = (byte_done_ev && (ph == PH_WR_DATA)) ||
                        (sck_fall_ev && (ph == PH_RD_DATA) && (out_cnt == 3'd7));
  assign out_ev       = sck_fall_ev && ((ph == PH_RD_DATA) || (ph == PH_RD_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      bit_cnt     <= '0;
      out_cnt     <= '0;
      shin        <= '0;
      addr        <= '0;
      wel         <= 1'b0;
      wr_cmd      <= 1'b0;
      rd_cmd      <= 1'b0;
      out_started <= 1'b0;
      guard_en    <= 1'b0;
      bp_f        <= 2'b00;
      so_d        <= 1'b0;
    end else if (sel_end_ev) begin
      ph          <= PH_IDLE;
      out_started <= 1'b0;
      wr_cmd      <= 1'b0;
      if (wr_cmd) wel <= 1'b0;
    end else if (sel_start_ev) begin
      ph          <= PH_CMD;
      bit_cnt     <= '0;
      out_cnt     <= '0;
      out_started <= 1'b0;
    end else begin
      if (sck_rise_ev) begin
        shin    <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done_ev) begin
        case (ph)
          PH_CMD: begin
            case (byte_in)
              CMD_WEN_SET: begin wel <= 1'b1; ph <= PH_DISCARD; end
              CMD_WEN_CLR: begin wel <= 1'b0; ph <= PH_DISCARD; end
              CMD_STAT_RD: ph <= PH_RD_STAT;
              CMD_STAT_WR: begin ph <= PH_WR_STAT; wr_cmd <= 1'b1; end
              CMD_ARR_RD:  begin ph <= PH_ADR_HI; rd_cmd <= 1'b1; end
              CMD_ARR_WR:  begin ph <= PH_ADR_HI; rd_cmd <= 1'b0; wr_cmd <= 1'b1; end
              default:     ph <= PH_DISCARD;
            endcase
          end
          PH_ADR_HI: begin
            addr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
            ph <= PH_ADR_LO;
          end
          PH_ADR_LO: begin
            addr[7:0] <= byte_in;
            ph <= rd_cmd ? PH_RD_DATA : PH_WR_DATA;
          end
          PH_WR_STAT: ph <= PH_DISCARD;
          default: ;
        endcase
      end
      if (status_wr_ev) begin
        guard_en <= byte_in[7];
        bp_f     <= byte_in[3:2];
      end
      if (addr_step_ev) addr <= addr_next(addr);
      if (out_ev) begin
        so_d        <= rd_byte[~out_cnt];
        out_cnt     <= out_cnt + 3'd1;
        out_started <= 1'b1;
      end
    end
  end

  assign mem_we    = array_wr_ev;
  assign mem_addr  = addr;
  assign mem_wdata = byte_in;
  assign rd_active = out_started && ((ph == PH_RD_DATA) || (ph == PH_RD_STAT));

  AST_SO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !sck_fall_ev |=> $stable(so_d)); // R3
  AST_CMD_ONCE: assert property (@(posedge clk) disable iff (!rst_n) (byte_done_ev && ph == PH_DISCARD) |=> (ph == PH_DISCARD)); // R2
  AST_ARRAY_WR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> wel); // R7
  AST_STAT_WR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) status_wr_ev |-> wel); // R7
  AST_STAT_GUARD: assert property (@(posedge clk) disable iff (!rst_n) status_wr_ev |-> !(guard_en && !wp_n)); // R8
  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (bp_f != 2'b11)); // R9
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (addr_step_ev && addr == '1) |=> (addr == '0)); // R10

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int ADDR_W   = SPI_ADDR_W,
  parameter int STORE_AW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so_d,
  output logic so_oe
);
  logic              held, sel_start_ev, sel_end_ev, sck_rise_ev, sck_fall_ev;
  logic              mem_we, rd_active;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  spimem_pins u_pins (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sck          (sck),
    .hold_n       (hold_n),
    .held         (held),
    .sel_start_ev (sel_start_ev),
    .sel_end_ev   (sel_end_ev),
    .sck_rise_ev  (sck_rise_ev),
    .sck_fall_ev  (sck_fall_ev)
  );

  spimem_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .si           (si),
    .wp_n         (wp_n),
    .sel_start_ev (sel_start_ev),
    .sel_end_ev   (sel_end_ev),
    .sck_rise_ev  (sck_rise_ev),
    .sck_fall_ev  (sck_fall_ev),
    .mem_rdata    (mem_rdata),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .so_d         (so_d),
    .rd_active    (rd_active)
  );

  spimem_store #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  assign so_oe = rd_active && !held && !cs_n;

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) held |-> !so_oe); // R5
  AST_NO_WRITE_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n) held |-> !mem_we); // R5

endmodule

// File: tb/test_spimem_slave.sv
module test_spimem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int STORE_AW   = 10;
  localparam int DEPTH      = 1 << STORE_AW;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wp_n;
  logic so_d, so_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spimem_slave #(.ADDR_W(15), .STORE_AW(STORE_AW)) i_spimem_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so_d(so_d), .so_oe(so_oe)
  );

  int   nchk, nerr;
  logic done;
  logic [7:0] mdl  [DEPTH];
  logic [7:0] wbuf [DEPTH];
  logic       mwel, mguard;
  logic [1:0] mbp;

  function automatic logic f_blk(input logic [1:0] bp, input logic [14:0] a);
    int lim;
    if (bp == 2'b00) return 1'b0;
    lim = (bp == 2'b01) ? 32'h6000 : (bp == 2'b10) ? 32'h4000 : 0;
    return int'(a) >= lim;
  endfunction

  function automatic logic [7:0] f_status();
    return {mguard, 3'b000, mbp, mwel, 1'b0};
  endfunction

  function automatic int f_idx(input logic [14:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; ticks(2);
  endtask

  task automatic desel();
    ticks(2); cs_n = 1'b1; ticks(2);
    chk("R11 so_oe low after deselect", so_oe, 0);
  endtask

  // One byte, MSB first; gbit >= 0 pulses hold while sck is high on that bit.
  task automatic xb(input logic [7:0] tx, output logic [7:0] rx, output int oe_cnt, input int gbit);
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      ticks(2);
      rx[i] = so_d;
      if (so_oe === 1'b1) oe_cnt++;
      sck = 1'b1;
      ticks(1);
      if (i == gbit) begin hold_n = 1'b0; ticks(1); hold_n = 1'b1; end
      else ticks(1);
      sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r; int oc;
    sel(); xb(op, r, oc, -1); desel();
    if (op == 8'h06) mwel = 1'b1;
    if (op == 8'h04) mwel = 1'b0;
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] r; int oc;
    sel(); xb(8'h01, r, oc, -1); xb(v, r, oc, -1); desel();
    if (mwel && !(mguard && !wp_n)) begin mguard = v[7]; mbp = v[3:2]; end
    mwel = 1'b0;
  endtask

  task automatic rd_status(input string tag);
    logic [7:0] r; int oc;
    sel();
    xb(8'h05, r, oc, -1);
    chk({"R11 no drive in command byte ", tag}, oc, 0);
    for (int k = 0; k < 2; k++) begin
      xb(8'h00, r, oc, -1);
      chk({"R8 status value ", tag}, r, f_status());
      chk({"R11 status byte driven ", tag}, oc, 8);
    end
    desel();
  endtask

  task automatic wr_array(input logic [15:0] a, input int n, input int gbit);
    logic [7:0] r; int oc; logic [14:0] aa;
    sel();
    xb(8'h02, r, oc, -1); xb(a[15:8], r, oc, -1); xb(a[7:0], r, oc, -1);
    for (int i = 0; i < n; i++) xb(wbuf[i], r, oc, (i == 0) ? gbit : -1);
    desel();
    aa = a[14:0];
    for (int i = 0; i < n; i++) begin
      if (mwel && !f_blk(mbp, aa)) mdl[f_idx(aa)] = wbuf[i];
      aa = aa + 15'd1;
    end
    mwel = 1'b0;
  endtask

  task automatic rd_array(input logic [15:0] a, input int n, input string tag);
    logic [7:0] r; int oc, oc_hdr; logic [14:0] aa;
    sel();
    oc_hdr = 0;
    xb(8'h03, r, oc, -1); oc_hdr += oc;
    xb(a[15:8], r, oc, -1); oc_hdr += oc;
    xb(a[7:0], r, oc, -1); oc_hdr += oc;
    chk({"R11 no drive before data ", tag}, oc_hdr, 0);
    aa = a[14:0];
    for (int i = 0; i < n; i++) begin
      xb(8'h00, r, oc, -1);
      chk({"R3 R10 read byte ", tag}, r, mdl[f_idx(aa)]);
      chk({"R11 data byte driven ", tag}, oc, 8);
      aa = aa + 15'd1;
    end
    desel();
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; int oc; logic [15:0] a; int n;
    logic [15:0] bnd [5];
    nchk = 0; nerr = 0;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1; rst_n = 1'b0;
    mwel = 1'b0; mguard = 1'b0; mbp = 2'b00;
    void'($urandom(32'h1F2E3D4C));
    ticks(4); rst_n = 1'b1; ticks(2);

    chk("R11 so_oe after reset", so_oe, 0);
    rd_status("reset");

    // R1: command pattern clocked while deselected
    for (int i = 7; i >= 0; i--) begin
      si = CMD_BIT(i);
      ticks(2); sck = 1'b1; ticks(2); sck = 1'b0;
      chk("R1 no drive while deselected", so_oe, 0);
    end
    rd_status("R1 wel still clear");

    // fill storage with a burst
    cmd1(8'h06);
    for (int i = 0; i < DEPTH; i++) wbuf[i] = 8'(i * 7 + 3);
    wr_array(16'h0000, DEPTH, -1);
    rd_array(16'h0000, 6, "fill");
    rd_status("R7 wel cleared after write");

    // R7: write without latch
    a = 16'h0100; wbuf[0] = ~mdl[f_idx(a[14:0])];
    wr_array(a, 1, -1);
    rd_array(a, 1, "R7 no wel");
    wr_status(8'h0C);
    rd_status("R7 status write without wel");
    cmd1(8'h06);
    rd_array(16'h0020, 2, "R7 read keeps wel");
    rd_status("R7 wel survives read");

    // R2: only first byte decoded
    sel(); xb(8'h04, r, oc, -1); xb(8'h06, r, oc, -1); desel(); mwel = 1'b0;
    rd_status("R2 second byte ignored");
    sel(); xb(8'h06, r, oc, -1); xb(8'h04, r, oc, -1); desel(); mwel = 1'b1;
    rd_status("R2 first byte taken");
    // R4: unknown command ignored
    cmd1(8'h04);
    sel(); xb(8'h9F, r, oc, -1); xb(8'h06, r, oc, -1); desel();
    rd_status("R4 unknown command");
    // R4: top address bit ignored
    cmd1(8'h06); wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    wr_array(16'h8123, 2, -1);
    rd_array(16'h0123, 2, "R4 top address bit");

    // R10: wrap in write and read
    cmd1(8'h06);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    wr_array(16'h7FFE, 4, -1);
    rd_array(16'h7FFE, 4, "R10 wrap");
    rd_array(16'h0000, 2, "R10 R12 alias after wrap");

    // R5: hold mid read
    a = 16'h0200;
    sel();
    xb(8'h03, r, oc, -1); xb(a[15:8], r, oc, -1); xb(a[7:0], r, oc, -1);
    xb(8'h00, r, oc, -1);
    chk("R5 byte before hold", r, mdl[f_idx(a[14:0])]);
    hold_n = 1'b0; ticks(3);
    chk("R5 no drive while held", so_oe, 0);
    for (int k = 0; k < 4; k++) begin
      si = ~si; sck = 1'b1; ticks(2); sck = 1'b0; ticks(2);
      chk("R5 no drive while held and clocked", so_oe, 0);
    end
    cs_n = 1'b1; ticks(3); cs_n = 1'b0; ticks(2);
    hold_n = 1'b1; ticks(3);
    xb(8'h00, r, oc, -1);
    chk("R5 byte after hold", r, mdl[f_idx(a[14:0] + 15'd1)]);
    chk("R5 drive resumes", oc, 8);
    desel();

    // R6: hold pulse while sck high
    cmd1(8'h06); a = 16'h0300; wbuf[0] = ~mdl[f_idx(a[14:0])];
    wr_array(a, 1, 4);
    rd_array(a, 1, "R6 hold pulse ignored");

    // R8: status guard
    cmd1(8'h06); wr_status(8'h80);
    rd_status("R8 guard set");
    wp_n = 1'b0;
    cmd1(8'h06); wr_status(8'h0C);
    rd_status("R8 guarded status write");
    cmd1(8'h06); a = 16'h0310; wbuf[0] = ~mdl[f_idx(a[14:0])];
    wr_array(a, 1, -1);
    rd_array(a, 1, "R8 array write under wp");
    wp_n = 1'b1;
    cmd1(8'h06); wr_status(8'h00);
    rd_status("R8 guard cleared with wp high");

    // R9: protect ranges at their boundaries
    bnd[0] = 16'h5FFF; bnd[1] = 16'h6000; bnd[2] = 16'h3FFF; bnd[3] = 16'h4000; bnd[4] = 16'h0010;
    for (int b = 1; b < 4; b++) begin
      cmd1(8'h06); wr_status({4'b0000, 2'(b), 2'b00});
      for (int k = 0; k < 5; k++) begin
        cmd1(8'h06); wbuf[0] = ~mdl[f_idx(bnd[k][14:0])];
        wr_array(bnd[k], 1, -1);
        rd_array(bnd[k], 1, "R9 protect boundary");
      end
      rd_array(16'h0000, 1, "R9 alias check");
    end
    cmd1(8'h06); wr_status(8'h00);
    rd_status("R9 ranges off");

    // random mix
    for (int it = 0; it < 30; it++) begin
      a = 16'($urandom); n = 1 + int'($urandom % 6);
      case ($urandom % 3)
        0: begin
          if (($urandom % 4) != 0) cmd1(8'h06);
          for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
          wr_array(a, n, -1);
        end
        1: rd_array(a, n, "R3 random read");
        default: begin
          cmd1(8'h06); wr_status({4'b0000, 2'($urandom), 2'b00});
          rd_status("R9 random range");
        end
      endcase
    end
    rd_array(16'h0000, 8, "R12 final");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  function automatic logic CMD_BIT(input int i);
    logic [7:0] v;
    v = 8'h06;
    return v[i];
  endfunction

endmodule